// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a small binary counter (4 bits by default) that counts up and down from two separate strobes, one per direction, instead of one clock and a direction select. A free-running system clock samples both strobes and counts on each rising edge it detects. A master clear and an active-low preset input take precedence over counting. While preset is low, the count tracks a parallel data word.

Two active-low terminal flags support chaining. The carry flag is low while the count sits at its maximum and the up strobe is low. The borrow flag is low while the count is zero and the down strobe is low. Wiring carry to the next stage's up strobe and borrow to its down strobe builds a wider counter out of identical stages. The idle strobe is meant to rest high, and the two strobes should never be low together. If both produce a rising edge in the same cycle, the count holds and a sticky conflict flag is raised.

Top module: `udc_counter`

## Requirements
- R1: A rising edge on `up_stb` raises `count` by one. A rising edge is `up_stb` sampled low at one clock edge and high at the next. The new count is visible after the second rising clock edge after the strobe goes high.
- R2: A rising edge on `dn_stb`, detected the same way, lowers `count` by one with the same two-edge latency.
- R3: Counting wraps modulo 2^WIDTH. Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R4: A clock edge with `mreset` high sets `count` to 0 and clears `conflict`, whatever the other inputs are. The flags then read high once the strobes have been sampled high.
- R5: At each clock edge with `mreset` low and `load_n` low, `count` takes `load_val`. Strobe edges detected during such cycles are discarded.
- R6: `carry_n` is 0 exactly when `count` is all ones and the last sampled `up_stb` level is 0. Otherwise it is 1. The sample is taken one clock edge after the pin changes.
- R7: `borrow_n` is 0 exactly when `count` is 0 and the last sampled `dn_stb` level is 0. Otherwise it is 1.
- R8: If rising edges on both strobes are detected in the same cycle, `count` keeps its value and `conflict` goes to 1. `conflict` stays at 1 until a reset.
- R9: The strobe sampling registers reset to the high idle level. A strobe held high across the release of reset therefore produces no count.
- R10: Two instances chained carry-to-up and borrow-to-down act as one counter of twice the width. The low stage's wrap moves the high stage by one in the same direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| mreset | input | 1 | Synchronous active-high master clear |
| up_stb | input | 1 | Count-up strobe, idle high |
| dn_stb | input | 1 | Count-down strobe, idle high |
| load_n | input | 1 | Active-low preset enable |
| load_val | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal-up flag |
| borrow_n | output | 1 | Active-low terminal-down flag |
| conflict | output | 1 | Sticky flag for simultaneous up and down edges |

## Verification
A strobe change shows up in the carry and borrow flags one clock edge later and in `count` two edges later. Preset and master clear reach `count` at the first edge. The bench keeps a cycle-level reference model that applies exactly these latencies. Inputs are driven on the falling clock edge, and every output is compared against the model at the next falling edge, so each result is sampled half a period after the rising edge that should produce it. The chained pair is checked only after enough idle cycles for a carry or borrow to pass through both stages.

// File: rtl/udc_pkg.sv
package udc_pkg;

  // Operation applied to the count register on the next clock edge.
  typedef enum logic [2:0] {
    UDC_HOLD  = 3'd0,
    UDC_INC   = 3'd1,
    UDC_DEC   = 3'd2,
    UDC_LOAD  = 3'd3,
    UDC_CLASH = 3'd4
  } udc_op_e;

endpackage

// File: rtl/udc_strobe_sense.sv
// Samples one strobe on the system clock and flags a low-to-high change.
// Both stages reset to the idle (high) level.
module udc_strobe_sense (
  input  logic clk,
  input  logic rst,
  input  logic stb_i,
  output logic level_o,
  output logic rise_o
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= 1'b1;
      stage2_q <= 1'b1;
    end else begin
      stage1_q <= stb_i;
      stage2_q <= stage1_q;
    end
  end

  assign level_o = stage1_q;
  assign rise_o  = stage1_q & ~stage2_q;

endmodule

// File: rtl/udc_op_select.sv
// Priority: preset, then conflicting edges, then up, then down.
module udc_op_select
  import udc_pkg::*;
(
  input  logic    load_n,
  input  logic    rise_up,
  input  logic    rise_dn,
  output udc_op_e op
);

  always_comb begin
    if (!load_n)                op = UDC_LOAD;
    else if (rise_up && rise_dn) op = UDC_CLASH;
    else if (rise_up)           op = UDC_INC;
    else if (rise_dn)           op = UDC_DEC;
    else                        op = UDC_HOLD;
  end

endmodule

// File: rtl/udc_count_core.sv
// Count register and sticky conflict flag.
module udc_count_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  udc_op_e          op,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             clash
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      clash <= 1'b0;
    end else begin
      case (op)
        UDC_LOAD:  count <= load_val;
        UDC_INC:   count <= count + STEP;
        UDC_DEC:   count <= count - STEP;
        UDC_CLASH: clash <= 1'b1;
        default:   count <= count;
      endcase
    end
  end

endmodule

// File: rtl/udc_term_flags.sv
// Active-low terminal flags, gated by the low phase of the matching strobe.
module udc_term_flags #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  assign carry_n  = ~((count == TOP) & ~up_lvl);
  assign borrow_n = ~((count == '0) & ~dn_lvl);

endmodule

// File: rtl/udc_counter.sv
module udc_counter
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             mreset,
  input  logic             up_stb,
  input  logic             dn_stb,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n,
  output logic             conflict
);

  localparam int NSTB = 2;  // index 0: up, index 1: down

  logic [NSTB-1:0] stb_vec;
  logic [NSTB-1:0] lvl_vec;
  logic [NSTB-1:0] rise_vec;
  udc_op_e         op;

  assign stb_vec = {dn_stb, up_stb};

  for (genvar g = 0; g < NSTB; g++) begin : g_sense
    udc_strobe_sense u_sense (
      .clk     (clk),
      .rst     (mreset),
      .stb_i   (stb_vec[g]),
      .level_o (lvl_vec[g]),
      .rise_o  (rise_vec[g])
    );
  end

  udc_op_select u_sel (
    .load_n  (load_n),
    .rise_up (rise_vec[0]),
    .rise_dn (rise_vec[1]),
    .op      (op)
  );

  udc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst      (mreset),
    .op       (op),
    .load_val (load_val),
    .count    (count),
    .clash    (conflict)
  );

  udc_term_flags #(.WIDTH(WIDTH)) u_flags (
    .count    (count),
    .up_lvl   (lvl_vec[0]),
    .dn_lvl   (lvl_vec[1]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

endmodule

// File: rtl/udc_counter_chk.sv
module udc_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             mreset,
  input logic             load_n,
  input logic [WIDTH-1:0] load_val,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             conflict
);

  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  // R4
  reset_clears_chk: assert property (@(posedge clk)
    mreset |=> (count == '0) && !conflict);

  // R5
  load_follow_chk: assert property (@(posedge clk) disable iff (mreset)
    !load_n |=> count == $past(load_val));

  // R1 R2 R3
  single_step_chk: assert property (@(posedge clk) disable iff (mreset)
    load_n |=> (count == $past(count)) || (count == $past(count) + STEP) ||
               (count == $past(count) - STEP));

  // R6
  carry_at_top_chk: assert property (@(posedge clk) disable iff (mreset)
    !carry_n |-> count == TOP);

  // R7
  borrow_at_zero_chk: assert property (@(posedge clk) disable iff (mreset)
    !borrow_n |-> count == '0);

  // R8
  conflict_sticky_chk: assert property (@(posedge clk) disable iff (mreset)
    conflict |=> conflict);

endmodule

bind udc_counter udc_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .mreset   (mreset),
  .load_n   (load_n),
  .load_val (load_val),
  .count    (count),
  .carry_n  (carry_n),
  .borrow_n (borrow_n),
  .conflict (conflict)
);

// File: tb/tb_udc_counter.sv
module tb_udc_counter;

  localparam int W = 4;
  localparam int TOPV = (1 << W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst = 1'b1, up = 1'b1, dn = 1'b1, ld_n = 1'b1;
  logic [W-1:0] ld_val = '0;
  logic [W-1:0] count;
  logic         carry_n, borrow_n, conflict;

  udc_counter #(.WIDTH(W)) dut (
    .clk(clk), .mreset(rst), .up_stb(up), .dn_stb(dn), .load_n(ld_n),
    .load_val(ld_val), .count(count), .carry_n(carry_n),
    .borrow_n(borrow_n), .conflict(conflict)
  );

  // Chained pair for R10
  logic         c_up = 1'b1, c_dn = 1'b1;
  logic [W-1:0] lo_cnt, hi_cnt;
  logic         lo_cy, lo_bw, hi_cy, hi_bw, lo_cf, hi_cf;

  udc_counter #(.WIDTH(W)) u_lo (
    .clk(clk), .mreset(rst), .up_stb(c_up), .dn_stb(c_dn), .load_n(1'b1),
    .load_val('0), .count(lo_cnt), .carry_n(lo_cy), .borrow_n(lo_bw),
    .conflict(lo_cf)
  );
  udc_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .mreset(rst), .up_stb(lo_cy), .dn_stb(lo_bw), .load_n(1'b1),
    .load_val('0), .count(hi_cnt), .carry_n(hi_cy), .borrow_n(hi_bw),
    .conflict(hi_cf)
  );

  int n_run = 0, n_fail = 0;

  // Reference model state
  int m_cnt = 0;
  bit m_err = 0, m_s1u = 1, m_s2u = 1, m_s1d = 1, m_s2d = 1;

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit ru, rd;
    if (rst) begin
      m_cnt = 0; m_err = 0; m_s1u = 1; m_s2u = 1; m_s1d = 1; m_s2d = 1;
    end else begin
      ru = m_s1u & ~m_s2u;
      rd = m_s1d & ~m_s2d;
      if (!ld_n)        m_cnt = int'(ld_val);
      else if (ru && rd) m_err = 1;
      else if (ru)      m_cnt = (m_cnt + 1) & TOPV;
      else if (rd)      m_cnt = (m_cnt + TOPV) & TOPV;
      m_s2u = m_s1u; m_s1u = up;
      m_s2d = m_s1d; m_s1d = dn;
    end
  endtask

  task automatic compare_all();
    check("R1 R2 R3 R5 count", int'(count), m_cnt);
    check("R6 carry_n", int'(carry_n), (m_cnt == TOPV && !m_s1u) ? 0 : 1);
    check("R7 borrow_n", int'(borrow_n), (m_cnt == 0 && !m_s1d) ? 0 : 1);
    check("R8 conflict", int'(conflict), int'(m_err));
  endtask

  // One system cycle: inputs were set at the previous falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic up_pulse();
    up = 1'b0; tick(); up = 1'b1; tick(); tick();
  endtask

  task automatic dn_pulse();
    dn = 1'b0; tick(); dn = 1'b1; tick(); tick();
  endtask

  task automatic do_load(int v);
    ld_n = 1'b0; ld_val = W'(v); tick(); ld_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    ticks(2);
    // R4 reset state
    check("R4 reset count", int'(count), 0);
    check("R4 reset carry_n", int'(carry_n), 1);
    check("R4 reset borrow_n", int'(borrow_n), 1);
    check("R4 reset conflict", int'(conflict), 0);
    rst = 1'b0;
    // R9: strobes held high across reset release
    ticks(4);
    check("R9 no false count", int'(count), 0);
    // R1, R2
    up_pulse(); up_pulse();
    check("R1 up twice", int'(count), 2);
    dn_pulse();
    check("R2 down once", int'(count), 1);
    // R3 wrap both ways
    do_load(TOPV);
    up_pulse();
    check("R3 wrap up", int'(count), 0);
    dn_pulse();
    check("R3 wrap down", int'(count), TOPV);
    // R6 carry at top while strobe low
    up = 1'b0; tick();
    check("R6 carry low", int'(carry_n), 0);
    up = 1'b1; tick();
    check("R6 carry released", int'(carry_n), 1);
    tick();
    // R7 borrow at zero while strobe low
    do_load(0);
    dn = 1'b0; tick();
    check("R7 borrow low", int'(borrow_n), 0);
    dn = 1'b1; tick();
    check("R7 borrow released", int'(borrow_n), 1);
    tick();
    // R5: edges during preset ignored
    ld_n = 1'b0; ld_val = 4'd5;
    up = 1'b0; tick(); up = 1'b1; tick(); tick(); tick();
    ld_n = 1'b1; tick(); tick();
    check("R5 preset ignores edge", int'(count), 5);
    // R8 conflict
    up = 1'b0; dn = 1'b0; tick();
    up = 1'b1; dn = 1'b1; tick(); tick(); tick();
    check("R8 count held", int'(count), 5);
    check("R8 flag set", int'(conflict), 1);
    ticks(3);
    check("R8 flag sticky", int'(conflict), 1);
    // R4 priority over preset
    rst = 1'b1; ld_n = 1'b0; ld_val = 4'd9; tick();
    check("R4 reset over preset", int'(count), 0);
    check("R4 reset clears flag", int'(conflict), 0);
    rst = 1'b0; ld_n = 1'b1; tick();
    // R10 chained pair
    for (int i = 0; i < 20; i++) begin
      c_up = 1'b0; ticks(2); c_up = 1'b1; ticks(2);
    end
    ticks(6);
    check("R10 chain up", int'({hi_cnt, lo_cnt}), 20);
    for (int i = 0; i < 5; i++) begin
      c_dn = 1'b0; ticks(2); c_dn = 1'b1; ticks(2);
    end
    ticks(6);
    check("R10 chain down", int'({hi_cnt, lo_cnt}), 15);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      int s;
      r = $urandom_range(0, 99);
      s = $urandom_range(0, 3);
      rst = (r < 2);
      ld_n = !(r >= 2 && r < 8);
      ld_val = W'($urandom);
      if (!up && !dn) begin
        up = 1'b1; dn = 1'b1;
      end else if (r >= 8 && r < 10) begin
        up = 1'b0; dn = 1'b0;
      end else if (s == 0 && dn) begin
        up = ~up;
      end else if (s == 1 && up) begin
        dn = ~dn;
      end
      tick();
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule